// File: doc/BRIEF.md
# Anti-Rollback Hash-Chain Key Sequencer

The sequencer derives a version-limited key from a stored root key. It applies a one-way compression function to the root key a number of times that depends on an 8-bit anti-rollback level. A fresh device has level zero and gets the longest chain, 255 rounds. Each step up in level removes exactly one round. A key issued at level c is therefore one hash short of the key at level c-1. Anyone who holds it can walk back to older levels, but nobody can move forward without inverting the hash. The same treatment is meant for every key slot, one derivation per start strobe.

Each round is delegated to an iterated hash unit over a request/acknowledge handshake. The digest of one round becomes the input of the next, and the remaining-round count moves only when the unit acknowledges. The test build includes a small local compression stage. It computes f(x) = rotl(x, ROT) XOR (x + K) modulo 2^W and takes HASH_LAT cycles per request. A second path, called step back, applies exactly one round to a key supplied by the caller. It returns the result with its own one-cycle done pulse, so software can check an image signed at an older level.

Top module: `hash_chain_seq`

## Requirements
- R1: After synchronous active-low reset, key_o and back_key_o are zero and done_o and back_done_o are low.
- R2: A start with level value c produces key_o = f applied (2^CNT_W - 1 - c) times to root_key_i, each round hashing the previous round's digest.
- R3: A start with c = 255 performs no hash: key_o equals root_key_i and done_o is high in the cycle right after the start edge.
- R4: done_o is a single-cycle pulse that rises N*(HASH_LAT+2) clock edges after the start edge, where N is the round count. key_o holds its value until the next result.
- R5: start_i and back_i are ignored while a derivation or step-back is in progress. The pending result, its timing and key_o are unaffected.
- R6: A back_i strobe hashes back_key_i once and presents the result on back_key_o with a single-cycle back_done_o pulse, HASH_LAT+2 edges after the strobe edge. key_o does not change.
- R7: If start_i and back_i are both high while idle, the derivation is served and the step-back request is dropped.
- R8: Stepping back the key derived at level c (c >= 1) yields the key derived at level c-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a derivation (sampled when idle) |
| level_i | input | CNT_W | Anti-rollback level for the derivation |
| root_key_i | input | W | Root key to be chained |
| back_i | input | 1 | Begin a single-round step-back |
| back_key_i | input | W | Key to be stepped back |
| key_o | output | W | Derived key, held until the next derivation |
| done_o | output | 1 | One-cycle pulse when key_o is updated |
| back_key_o | output | W | Step-back result |
| back_done_o | output | 1 | One-cycle pulse when back_key_o is updated |

## Verification
A wrong round count or a feedback error shows up as a wrong key_o, but only at the done pulse. That can be up to 255*(HASH_LAT+2) cycles after the start, so each level is checked against a behavioural chain computed in the bench. A counter that moves without an acknowledge, or a busy flag that is lost, shifts done_o away from its predicted cycle. The bench compares done_o, back_done_o and both key outputs on every clock, so such a fault is caught in the first cycle it appears. Ignored strobes are proven by unchanged timing and values of the pending result.

// File: rtl/hcs_pkg.sv
// Shared types for the hash-chain key sequencer.
package hcs_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_CHAIN = 2'd1,
        SEQ_BACK = 2'd2
    } seq_state_e;
endpackage

// File: rtl/hcs_mix.sv
// Iterated hash unit: one compression round per accepted request.
// Assumes the requester holds req_i and din_i stable until ack_o.
// A request is accepted only when idle and not in the ack cycle, so a
// stale operand is never taken. Latency is LAT (>= 1) cycles plus handshake.
module hcs_mix #(
    parameter int W = 32,
    parameter int LAT = 2,
    parameter int ROT = 7,
    parameter logic [W-1:0] K = W'(32'h9E3779B9)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_i,
    input  logic [W-1:0] din_i,
    output logic         ack_o,
    output logic [W-1:0] dout_o
);
    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

    logic          busy;
    logic [CW-1:0] cnt;
    logic [W-1:0]  hold;

    function automatic logic [W-1:0] mix_f(input logic [W-1:0] x);
        return ((x << ROT) | (x >> (W - ROT))) ^ (x + K);
    endfunction

    // Accept an operand, count latency, then return the digest with ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            hold   <= '0;
            ack_o  <= 1'b0;
            dout_o <= '0;
        end else begin
            ack_o <= 1'b0;
            if (!busy) begin
                if (req_i && !ack_o) begin
                    hold <= din_i;
                    cnt  <= CW'(LAT - 1);
                    busy <= 1'b1;
                end
            end else if (cnt == '0) begin
                dout_o <= mix_f(hold);
                ack_o  <= 1'b1;
                busy   <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R4
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> req_i);
endmodule

// File: rtl/hcs_ctrl.sv
// Sequencer: derives key = f^(MAX-level)(root) through the hash unit,
// and serves single-round step-back requests. Assumes the hash unit
// acknowledges each request exactly once. Strobes are ignored unless idle.
module hcs_ctrl
    import hcs_pkg::*;
#(
    parameter int W = 32,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] level_i,
    input  logic [W-1:0]     root_key_i,
    input  logic             back_i,
    input  logic [W-1:0]     back_key_i,
    output logic             req_o,
    output logic [W-1:0]     din_o,
    input  logic             ack_i,
    input  logic [W-1:0]     dout_i,
    output logic [W-1:0]     key_o,
    output logic             done_o,
    output logic [W-1:0]     back_key_o,
    output logic             back_done_o
);
    localparam logic [CNT_W-1:0] MAXC = '1;

    seq_state_e       st;
    logic [CNT_W-1:0] rem;
    logic [W-1:0]     work;

    // Present the running digest to the hash unit while busy.
    always_comb begin
        req_o = (st != SEQ_IDLE);
        din_o = work;
    end

    // Sequence start, round countdown, feedback and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= SEQ_IDLE;
            rem         <= '0;
            work        <= '0;
            key_o       <= '0;
            done_o      <= 1'b0;
            back_key_o  <= '0;
            back_done_o <= 1'b0;
        end else begin
            done_o      <= 1'b0;
            back_done_o <= 1'b0;
            case (st)
                SEQ_IDLE: begin
                    if (start_i) begin
                        if (level_i == MAXC) begin
                            key_o  <= root_key_i;
                            done_o <= 1'b1;
                        end else begin
                            work <= root_key_i;
                            rem  <= MAXC - level_i;
                            st   <= SEQ_CHAIN;
                        end
                    end else if (back_i) begin
                        work <= back_key_i;
                        st   <= SEQ_BACK;
                    end
                end
                SEQ_CHAIN: begin
                    if (ack_i) begin
                        work <= dout_i;
                        rem  <= rem - 1'b1;
                        if (rem == CNT_W'(1)) begin
                            key_o  <= dout_i;
                            done_o <= 1'b1;
                            st     <= SEQ_IDLE;
                        end
                    end
                end
                SEQ_BACK: begin
                    if (ack_i) begin
                        back_key_o  <= dout_i;
                        back_done_o <= 1'b1;
                        st          <= SEQ_IDLE;
                    end
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end

    // R3
    full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_IDLE && start_i && level_i == MAXC)
            |=> (done_o && key_o == $past(root_key_i)));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_CHAIN && !ack_i) |=> (st == SEQ_CHAIN && rem == $past(rem)));

    // R6
    back_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_BACK) |=> $stable(key_o));

    // R7
    start_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_IDLE && start_i && back_i && level_i != MAXC)
            |=> (st == SEQ_CHAIN));
endmodule

// File: rtl/hash_chain_seq.sv
// Top: anti-rollback hash-chain key sequencer with a local hash unit.
// Round count is (2^CNT_W - 1) - level; a step-back applies one round.
module hash_chain_seq #(
    parameter int W = 32,
    parameter int CNT_W = 8,
    parameter int HASH_LAT = 2,
    parameter int ROT = 7,
    parameter logic [W-1:0] K = W'(32'h9E3779B9)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] level_i,
    input  logic [W-1:0]     root_key_i,
    input  logic             back_i,
    input  logic [W-1:0]     back_key_i,
    output logic [W-1:0]     key_o,
    output logic             done_o,
    output logic [W-1:0]     back_key_o,
    output logic             back_done_o
);
    logic         h_req;
    logic         h_ack;
    logic [W-1:0] h_din;
    logic [W-1:0] h_dout;

    hcs_ctrl #(.W(W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_i), .level_i(level_i), .root_key_i(root_key_i),
        .back_i(back_i), .back_key_i(back_key_i),
        .req_o(h_req), .din_o(h_din), .ack_i(h_ack), .dout_i(h_dout),
        .key_o(key_o), .done_o(done_o),
        .back_key_o(back_key_o), .back_done_o(back_done_o)
    );

    hcs_mix #(.W(W), .LAT(HASH_LAT), .ROT(ROT), .K(K)) u_mix (
        .clk(clk), .rst_n(rst_n),
        .req_i(h_req), .din_i(h_din),
        .ack_o(h_ack), .dout_o(h_dout)
    );

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!done_o && !back_done_o && key_o == '0 && back_key_o == '0));
endmodule

// File: tb/hash_chain_seq_tb.sv
module hash_chain_seq_tb;
    localparam int W = 32;
    localparam int CNT_W = 8;
    localparam int LAT = 2;
    localparam int ROT = 7;
    localparam logic [W-1:0] KC = 32'h9E3779B9;
    localparam int MAXL = 255;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic back_i = 1'b0;
    logic [CNT_W-1:0] level_i = '0;
    logic [W-1:0] root_key_i = '0;
    logic [W-1:0] back_key_i = '0;
    logic [W-1:0] key_o, back_key_o;
    logic done_o, back_done_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int busy_until = 0;
    int exp_edge = -1;
    int exp_bedge = -1;
    logic [W-1:0] pend_key = '0, cur_key = '0;
    logic [W-1:0] pend_bkey = '0, cur_bkey = '0;
    logic checking = 1'b0;
    logic [W-1:0] saved;

    hash_chain_seq #(.W(W), .CNT_W(CNT_W), .HASH_LAT(LAT), .ROT(ROT), .K(KC)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .level_i(level_i),
        .root_key_i(root_key_i), .back_i(back_i), .back_key_i(back_key_i),
        .key_o(key_o), .done_o(done_o), .back_key_o(back_key_o),
        .back_done_o(back_done_o)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [W-1:0] one_round(input logic [W-1:0] x);
        logic [W-1:0] r;
        r = {x[W-ROT-1:0], x[W-1:W-ROT]};
        return r ^ (x + KC);
    endfunction

    function automatic logic [W-1:0] chain(input logic [W-1:0] x, input int n);
        logic [W-1:0] v;
        v = x;
        for (int i = 0; i < n; i++) v = one_round(v);
        return v;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Reference comparison on every clock (R2 R4 R6).
    always @(negedge clk) begin
        if (checking) begin
            if (cyc == exp_edge) cur_key = pend_key;
            if (cyc == exp_bedge) cur_bkey = pend_bkey;
            check("R4 done_o", W'(done_o), W'(cyc == exp_edge));
            check("R2 key_o", key_o, cur_key);
            check("R6 back_done_o", W'(back_done_o), W'(cyc == exp_bedge));
            check("R6 back_key_o", back_key_o, cur_bkey);
        end
    end

    // Drive one strobe cycle and update the model when the design is idle.
    task automatic issue(input logic s, input logic b, input int lvl,
                         input logic [W-1:0] root, input logic [W-1:0] bk);
        int n;
        @(negedge clk); #1;
        start_i = s; back_i = b; level_i = CNT_W'(lvl);
        root_key_i = root; back_key_i = bk;
        if (cyc >= busy_until) begin
            if (s) begin
                n = MAXL - lvl;
                exp_edge = cyc + 1 + n * (LAT + 2);
                pend_key = chain(root, n);
                busy_until = exp_edge;
            end else if (b) begin
                exp_bedge = cyc + 1 + LAT + 2;
                pend_bkey = one_round(bk);
                busy_until = exp_bedge;
            end
        end
        @(negedge clk); #1;
        start_i = 1'b0; back_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (cyc <= busy_until + 1) @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 key_o", key_o, '0);
        check("R1 back_key_o", back_key_o, '0);
        check("R1 done_o", W'(done_o), '0);
        check("R1 back_done_o", W'(back_done_o), '0);
        #1 rst_n = 1'b1;
        checking = 1'b1;

        // R3 top level, no hashing
        issue(1'b1, 1'b0, 255, 32'hCAFE_0001, '0); wait_idle();
        // R2 R4 single and multi round chains
        issue(1'b1, 1'b0, 254, 32'h1234_5678, '0); wait_idle();
        issue(1'b1, 1'b0, 200, 32'hA5A5_0F0F, '0); wait_idle();
        saved = key_o;
        issue(1'b1, 1'b0, 0, 32'h0BAD_F00D, '0); wait_idle();
        // R8 step back from level 200 equals level 199 key
        issue(1'b0, 1'b1, 0, '0, saved); wait_idle();
        issue(1'b1, 1'b0, 199, 32'hA5A5_0F0F, '0); wait_idle();
        check("R8 back of level 200 vs level 199", back_key_o, key_o);
        // R5 strobes while busy ignored
        issue(1'b1, 1'b0, 250, 32'hDEAD_BEEF, '0);
        issue(1'b1, 1'b0, 255, 32'h1111_1111, '0);
        issue(1'b0, 1'b1, 0, '0, 32'h2222_2222);
        wait_idle();
        // R7 start and back together
        issue(1'b1, 1'b1, 253, 32'h7777_0000, 32'h3333_3333); wait_idle();
        issue(1'b1, 1'b1, 255, 32'h4444_5555, 32'h6666_6666); wait_idle();
        // R6 step back leaves key_o alone
        issue(1'b0, 1'b1, 0, '0, 32'hFFFF_FFFF); wait_idle();
        issue(1'b1, 1'b0, 128, 32'h0000_0001, '0); wait_idle();

        checking = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule